// File: doc/BRIEF.md
# Configuration Request Packer

This block turns one configuration-space access into the beats of a request packet for a 64-bit transmit path. A requester presents a read or a write with a target bus, a device/function number, a byte offset, an access size of one, two or four bytes and, for writes, the data. The block works out the byte enables and moves narrow write data into its byte lanes. It picks the local header type (0) or the routed header type (1) by comparing the target bus with the root bus number it keeps. It then builds the three header dwords and sends them, with the data, as two or three beats marked with start and end flags.

The transmit side accepts beats with a valid/ready handshake and may stall at any beat. While a packet is being sent the request port reports not ready, so a request offered then has no effect. A separate completion strobe reports whether the last request finished without error. When that request was a write to the root port's primary-bus register, a good completion loads the root bus number from the low byte of the lane-aligned write data. From then on, that number is used for the header type choice and for the requester ID.

Top module: `cfg_tlp_packer`

## Requirements
- R1: Byte enables (8-bit field) are 0x01 shifted left by offset[1:0] for size code 0 (one byte), 0x03 shifted left by offset[1:0] for size code 1 (two bytes), and 0x0F for size codes 2 and 3 (four bytes), truncated to 8 bits.
- R2: Write data is placed in lanes: size 0 keeps data[7:0], size 1 keeps data[15:0], and either is shifted left by 8 × offset[1:0] within 32 bits. Sizes 2 and 3 pass all 32 bits unchanged.
- R3: Header dword 0 is {format/type, 24'h000001}. Format/type is 0x04 for a read and 0x44 for a write when the target bus equals the root bus number, and 0x05 for a read and 0x45 for a write otherwise.
- R4: Header dword 1 is {root bus number, 8'h00, tag, byte enables}. The tag is 0x1D for reads and 0x10 for writes.
- R5: Header dword 2 is {bus, devfn, offset zero-extended to 16 bits with bits 1:0 cleared}.
- R6: The first beat carries dword 0 in bits 31:0 and dword 1 in bits 63:32, with the start flag set and the end flag clear.
- R7: A write whose offset has bit 2 clear takes three beats. The second beat is {32'h0, dword 2} with neither flag set, and the third is {32'h0, lane data} with the end flag set.
- R8: A write whose offset has bit 2 set, and every read, takes two beats. The second beat is {lane data, dword 2} for writes and {32'h0, dword 2} for reads, with the end flag set.
- R9: While a beat is valid and not accepted, the next cycle shows the same beat data and flags.
- R10: The request port is ready only when no beat is pending. It drops in the cycle after a request is accepted and rises in the cycle after the end beat is accepted. A request offered while it is low produces no beats.
- R11: A write to the root bus at dword offset 0x18 arms an update. The next completion strobe with the success bit set loads the root bus number from bits 7:0 of the lane data. A failed completion, or a completion for any other request, leaves the number unchanged.
- R12: After reset, the request port is ready, no beat is valid and the root bus number equals the ROOT_RST parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request port idle; accept happens when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function |
| req_ofs | input | OFS_W | Byte offset in configuration space |
| req_size | input | 2 | Size code: 0 one byte, 1 two bytes, 2 or 3 four bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| cpl_valid | input | 1 | Completion strobe for the last request |
| cpl_ok | input | 1 | Completion finished without error |
| beat_valid | output | 1 | Beat present |
| beat_ready | input | 1 | Beat accepted when both are high |
| beat_data | output | 64 | Beat payload, first dword in bits 31:0 |
| beat_sop | output | 1 | First beat of the packet |
| beat_eop | output | 1 | Last beat of the packet |

## Verification
The hardest case to reach from the ports is a change of the root bus number. It needs a write to the root bus at the primary-bus dword, then a separate completion with the success bit, and only a later request's header shows the effect. The stimulus therefore writes the register and strobes a good completion. It then reads a bus that was routed before and checks that it now gets the local header type and the new requester ID. Failed completions and writes aimed at another bus follow, and their headers show no change. A second request is held on the port while the transmit side stalls, to show that it is dropped and that the pending beat does not change.

// File: rtl/cfgpk_pkg.sv
package cfgpk_pkg;
  localparam int BUS_W  = 8;
  localparam int DW_W   = 32;
  localparam int BEAT_W = 2 * DW_W;
  localparam int BE_W   = 8;

  localparam logic [7:0] FT_RD_LOCAL  = 8'h04;
  localparam logic [7:0] FT_WR_LOCAL  = 8'h44;
  localparam logic [7:0] FT_RD_ROUTED = 8'h05;
  localparam logic [7:0] FT_WR_ROUTED = 8'h45;
  localparam logic [7:0] TAG_RD       = 8'h1D;
  localparam logic [7:0] TAG_WR       = 8'h10;
  localparam logic [23:0] LEN_FIELD   = 24'h000001;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_MID  = 2'd2,
    ST_DATA = 2'd3
  } seq_st_e;

  typedef struct packed {
    logic [DW_W-1:0] dw0;
    logic [DW_W-1:0] dw1;
    logic [DW_W-1:0] dw2;
    logic [DW_W-1:0] pay;
    logic            three;
  } pkt_t;
endpackage

// File: rtl/cfgpk_lane.sv
module cfgpk_lane
  import cfgpk_pkg::*;
(
  input  logic [1:0]      size,
  input  logic [1:0]      ofs_lo,
  input  logic [DW_W-1:0] wdata,
  output logic [BE_W-1:0] be,
  output logic [DW_W-1:0] lane_data
);
  logic [4:0]      shamt;
  logic [BE_W-1:0] be_base;
  logic [DW_W-1:0] d_base;

  assign shamt = {ofs_lo, 3'b000};

  always_comb begin
    be_base = 8'h0F;
    d_base  = wdata;
    if (size == SZ_BYTE) begin
      be_base = 8'h01;
      d_base  = {24'h0, wdata[7:0]};
    end else if (size == SZ_HALF) begin
      be_base = 8'h03;
      d_base  = {16'h0, wdata[15:0]};
    end
  end

  always_comb begin
    if (size == SZ_BYTE || size == SZ_HALF) begin
      be        = be_base << ofs_lo;
      lane_data = d_base << shamt;
    end else begin
      be        = be_base;
      lane_data = d_base;
    end
  end
endmodule

// File: rtl/cfgpk_hdr.sv
module cfgpk_hdr
  import cfgpk_pkg::*;
#(
  parameter int OFS_W = 12
) (
  input  logic             write,
  input  logic [BUS_W-1:0] bus,
  input  logic [7:0]       devfn,
  input  logic [OFS_W-1:2] ofs_hi,
  input  logic [BE_W-1:0]  be,
  input  logic [DW_W-1:0]  lane_data,
  input  logic [BUS_W-1:0] root,
  output pkt_t             pkt
);
  logic       routed;
  logic [7:0] ftype;
  logic [7:0] tag;
  logic [15:0] ofs16;

  assign routed = (bus != root);

  always_comb begin
    case ({write, routed})
      2'b00:   ftype = FT_RD_LOCAL;
      2'b01:   ftype = FT_RD_ROUTED;
      2'b10:   ftype = FT_WR_LOCAL;
      default: ftype = FT_WR_ROUTED;
    endcase
    tag = write ? TAG_WR : TAG_RD;
  end

  always_comb begin
    ofs16 = '0;
    ofs16[OFS_W-1:2] = ofs_hi;
  end

  always_comb begin
    pkt.dw0   = {ftype, LEN_FIELD};
    pkt.dw1   = {root, 8'h00, tag, be};
    pkt.dw2   = {bus, devfn, ofs16};
    pkt.pay   = write ? lane_data : '0;
    pkt.three = write & ~ofs_hi[2];
  end
endmodule

// File: rtl/cfgpk_seq.sv
module cfgpk_seq
  import cfgpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  pkt_t              pkt_in,
  input  logic              beat_ready,
  output logic              busy,
  output logic              beat_valid,
  output logic [BEAT_W-1:0] beat_data,
  output logic              beat_sop,
  output logic              beat_eop
);
  seq_st_e st_q, st_d;
  pkt_t    pkt_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (load)       st_d = ST_HDR;
      ST_HDR:  if (beat_ready) st_d = ST_MID;
      ST_MID:  if (beat_ready) st_d = pkt_q.three ? ST_DATA : ST_IDLE;
      ST_DATA: if (beat_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (load) pkt_q <= pkt_in;
  end

  always_comb begin
    beat_data = '0;
    beat_sop  = 1'b0;
    beat_eop  = 1'b0;
    case (st_q)
      ST_HDR: begin
        beat_data = {pkt_q.dw1, pkt_q.dw0};
        beat_sop  = 1'b1;
      end
      ST_MID: begin
        beat_data = pkt_q.three ? {{DW_W{1'b0}}, pkt_q.dw2} : {pkt_q.pay, pkt_q.dw2};
        beat_eop  = ~pkt_q.three;
      end
      ST_DATA: begin
        beat_data = {{DW_W{1'b0}}, pkt_q.pay};
        beat_eop  = 1'b1;
      end
      default: ;
    endcase
  end

  assign beat_valid = (st_q != ST_IDLE);
  assign busy       = (st_q != ST_IDLE);
endmodule

// File: rtl/cfgpk_root.sv
module cfgpk_root
  import cfgpk_pkg::*;
#(
  parameter int              OFS_W       = 12,
  parameter logic [BUS_W-1:0] ROOT_RST   = '0,
  parameter int              PRIMARY_OFS = 'h18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             write,
  input  logic [BUS_W-1:0] bus,
  input  logic [OFS_W-1:2] ofs_hi,
  input  logic [7:0]       lane_lo,
  input  logic             cpl_valid,
  input  logic             cpl_ok,
  output logic [BUS_W-1:0] root
);
  localparam int HI_W = OFS_W - 2;
  localparam logic [HI_W-1:0] PRIM_HI = HI_W'(PRIMARY_OFS >> 2);

  logic             pend_q, pend_d;
  logic [7:0]       val_q, val_d;
  logic [BUS_W-1:0] root_q, root_d;
  logic             hit;
  logic             val_en;

  assign hit = accept & write & (bus == root_q) & (ofs_hi == PRIM_HI);

  always_comb begin
    pend_d = pend_q;
    root_d = root_q;
    val_d  = lane_lo;
    val_en = accept;
    if (cpl_valid) begin
      if (pend_q && cpl_ok) root_d = val_q;
      pend_d = 1'b0;
    end
    if (accept) pend_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      root_q <= ROOT_RST;
    end else begin
      pend_q <= pend_d;
      root_q <= root_d;
    end
  end

  always_ff @(posedge clk) begin
    if (val_en) val_q <= val_d;
  end

  assign root = root_q;
endmodule

// File: rtl/cfg_tlp_packer.sv
module cfg_tlp_packer
  import cfgpk_pkg::*;
#(
  parameter int              OFS_W       = 12,
  parameter logic [7:0]      ROOT_RST    = 8'h00,
  parameter int              PRIMARY_OFS = 'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [7:0]        req_bus,
  input  logic [7:0]        req_devfn,
  input  logic [OFS_W-1:0]  req_ofs,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic              cpl_valid,
  input  logic              cpl_ok,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [63:0]       beat_data,
  output logic              beat_sop,
  output logic              beat_eop
);
  logic [BE_W-1:0]  be;
  logic [DW_W-1:0]  lane_data;
  logic [BUS_W-1:0] root;
  pkt_t             pkt;
  logic             busy;
  logic             accept;

  assign req_ready = ~busy;
  assign accept    = req_valid & ~busy;

  cfgpk_lane u_lane (
    .size      (req_size),
    .ofs_lo    (req_ofs[1:0]),
    .wdata     (req_wdata),
    .be        (be),
    .lane_data (lane_data)
  );

  cfgpk_hdr #(.OFS_W(OFS_W)) u_hdr (
    .write     (req_write),
    .bus       (req_bus),
    .devfn     (req_devfn),
    .ofs_hi    (req_ofs[OFS_W-1:2]),
    .be        (be),
    .lane_data (lane_data),
    .root      (root),
    .pkt       (pkt)
  );

  cfgpk_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .pkt_in     (pkt),
    .beat_ready (beat_ready),
    .busy       (busy),
    .beat_valid (beat_valid),
    .beat_data  (beat_data),
    .beat_sop   (beat_sop),
    .beat_eop   (beat_eop)
  );

  cfgpk_root #(
    .OFS_W       (OFS_W),
    .ROOT_RST    (ROOT_RST),
    .PRIMARY_OFS (PRIMARY_OFS)
  ) u_root (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .write     (req_write),
    .bus       (req_bus),
    .ofs_hi    (req_ofs[OFS_W-1:2]),
    .lane_lo   (lane_data[7:0]),
    .cpl_valid (cpl_valid),
    .cpl_ok    (cpl_ok),
    .root      (root)
  );
endmodule

// File: rtl/cfg_tlp_packer_chk.sv
module cfg_tlp_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        beat_valid,
  input logic        beat_ready,
  input logic [63:0] beat_data,
  input logic        beat_sop,
  input logic        beat_eop
);
  // R9: a stalled beat holds
  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_data) && $stable(beat_sop) && $stable(beat_eop));

  // R10: request port closed while a beat is pending
  a_r10_busy_block: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !req_ready);

  // R10 / R6: an accepted request opens with a start beat
  a_r10_accept_sop: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> beat_valid && beat_sop);

  // R6: start beat never ends the packet
  a_r6_sop_not_eop: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_sop |-> !beat_eop);

  // R10: accepted end beat frees the port
  a_r10_eop_release: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_eop && beat_ready |=> req_ready && !beat_valid);

  // R3: start beat carries a legal format/type code
  a_r3_fmt_code: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_sop |-> (beat_data[31:24] == 8'h04 || beat_data[31:24] == 8'h44 ||
                                beat_data[31:24] == 8'h05 || beat_data[31:24] == 8'h45));
endmodule

bind cfg_tlp_packer cfg_tlp_packer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .beat_data  (beat_data),
  .beat_sop   (beat_sop),
  .beat_eop   (beat_eop)
);

// File: tb/cfg_tlp_packer_bench.sv
module cfg_tlp_packer_bench;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [7:0]  req_bus;
  logic [7:0]  req_devfn;
  logic [11:0] req_ofs;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        cpl_valid;
  logic        cpl_ok;
  logic        beat_valid;
  logic        beat_ready;
  logic [63:0] beat_data;
  logic        beat_sop;
  logic        beat_eop;

  int checks;
  int failures;
  bit finished;

  logic [7:0]  root_m;
  logic        pend_m;
  logic [7:0]  pval_m;

  logic [63:0] eb [3];
  logic        es [3];
  logic        ee [3];
  int          en;
  logic [63:0] rb [4];

  cfg_tlp_packer u_cfg_tlp_packer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_ofs(req_ofs),
    .req_size(req_size), .req_wdata(req_wdata),
    .cpl_valid(cpl_valid), .cpl_ok(cpl_ok),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_data(beat_data),
    .beat_sop(beat_sop), .beat_eop(beat_eop)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  // Expected beats, built from the requirements
  task automatic build_exp(input logic w, input logic [7:0] bus, input logic [7:0] devfn,
                           input logic [11:0] ofs, input logic [1:0] size, input logic [31:0] d);
    logic [7:0]  be;
    logic [31:0] ld;
    logic [7:0]  ft;
    logic [31:0] dw0, dw1, dw2;
    case (size)
      2'd0: begin be = 8'h01 << ofs[1:0]; ld = {24'h0, d[7:0]} << (8 * ofs[1:0]); end
      2'd1: begin be = 8'h03 << ofs[1:0]; ld = {16'h0, d[15:0]} << (8 * ofs[1:0]); end
      default: begin be = 8'h0F; ld = d; end
    endcase
    if (bus == root_m) ft = w ? 8'h44 : 8'h04;
    else               ft = w ? 8'h45 : 8'h05;
    dw0 = {ft, 24'h000001};
    dw1 = {root_m, 8'h00, (w ? 8'h10 : 8'h1D), be};
    dw2 = {bus, devfn, 4'h0, ofs[11:2], 2'b00};
    eb[0] = {dw1, dw0}; es[0] = 1'b1; ee[0] = 1'b0;
    if (w && !ofs[2]) begin
      en = 3;
      eb[1] = {32'h0, dw2}; es[1] = 1'b0; ee[1] = 1'b0;
      eb[2] = {32'h0, ld};  es[2] = 1'b0; ee[2] = 1'b1;
    end else begin
      en = 2;
      eb[1] = {(w ? ld : 32'h0), dw2}; es[1] = 1'b0; ee[1] = 1'b1;
    end
    if (w && bus == root_m && ofs[11:2] == 10'h006) begin
      pend_m = 1'b1;
      pval_m = ld[7:0];
    end else begin
      pend_m = 1'b0;
    end
  endtask

  task automatic send(input logic w, input logic [7:0] bus, input logic [7:0] devfn,
                      input logic [11:0] ofs, input logic [1:0] size, input logic [31:0] d);
    build_exp(w, bus, devfn, ofs, size, d);
    @(negedge clk);
    chk("R10 idle ready", {63'h0, req_ready}, 64'h1);
    req_valid = 1'b1; req_write = w; req_bus = bus; req_devfn = devfn;
    req_ofs = ofs; req_size = size; req_wdata = d;
    @(posedge clk);
  endtask

  task automatic collect(input string tag, input bit stall);
    int  got;
    int  k;
    bit  done;
    logic [63:0] held;
    got = 0; k = 0; done = 0; held = '0;
    for (int guard = 0; guard < 40 && !done; guard++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (stall && (k % 3) != 2) begin
        beat_ready = 1'b0;
        if ((k % 3) == 0) held = beat_data;
        k++;
      end else begin
        beat_ready = 1'b1;
        if (stall) chk("R9 stalled beat held", beat_data, held);
        k++;
        chk({tag, " beat valid"}, {63'h0, beat_valid}, 64'h1);
        if (got < en) begin
          chk({tag, " beat data"}, beat_data, eb[got]);
          chk({tag, " start flag"}, {63'h0, beat_sop}, {63'h0, es[got]});
          chk({tag, " end flag"}, {63'h0, beat_eop}, {63'h0, ee[got]});
        end
        if (got < 4) rb[got] = beat_data;
        got++;
        if (beat_eop || !beat_valid) done = 1;
      end
    end
    @(negedge clk);
    beat_ready = 1'b0;
    chk({tag, " beat count"}, 64'(got), 64'(en));
    chk("R10 ready after end beat", {62'h0, req_ready, beat_valid}, 64'h2);
  endtask

  task automatic complete(input logic ok);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_ok = ok;
    @(negedge clk);
    cpl_valid = 1'b0; cpl_ok = 1'b0;
    if (ok && pend_m) root_m = pval_m;
    pend_m = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12 ready after reset", {63'h0, req_ready}, 64'h1);
    chk("R12 no beat after reset", {63'h0, beat_valid}, 64'h0);
  endtask

  task automatic t_read_local();
    send(1'b0, 8'h00, 8'h00, 12'h010, 2'd2, 32'hDEAD_BEEF);
    collect("R3/R4/R5/R6/R8/R12 local read", 1'b0);
    chk("R12 requester id uses reset root", {56'h0, rb[0][63:56]}, 64'h00);
    complete(1'b1);
  endtask

  task automatic t_read_routed();
    send(1'b0, 8'h03, 8'h08, 12'h00E, 2'd1, 32'h0);
    collect("R3/R5/R8 routed read", 1'b0);
    chk("R1 half enables at offset 2", {56'h0, rb[0][39:32]}, 64'h0C);
    chk("R3 routed read code", {56'h0, rb[0][31:24]}, 64'h05);
    complete(1'b1);
  endtask

  task automatic t_write_aligned_byte();
    send(1'b1, 8'h00, 8'h00, 12'h023, 2'd0, 32'h1234_56A5);
    collect("R2/R7 aligned byte write", 1'b0);
    chk("R1 byte enable at offset 3", {56'h0, rb[0][39:32]}, 64'h08);
    chk("R2 byte moved to top lane", rb[2], 64'h0000_0000_A500_0000);
    complete(1'b1);
  endtask

  task automatic t_write_unaligned_half();
    send(1'b1, 8'h01, 8'h10, 12'h007, 2'd1, 32'hFFFF_BEEF);
    collect("R2/R8 unaligned half write", 1'b0);
    chk("R1 half enables truncated to 8 bits", {56'h0, rb[0][39:32]}, 64'h18);
    chk("R8 data in upper half", {32'h0, rb[1][63:32]}, 64'hEF00_0000);
    complete(1'b1);
  endtask

  task automatic t_stall_write();
    send(1'b1, 8'h02, 8'h00, 12'h040, 2'd3, 32'hCAFE_F00D);
    collect("R7/R9 stalled aligned write", 1'b1);
    complete(1'b1);
  endtask

  task automatic t_busy_drop();
    logic [63:0] first;
    send(1'b0, 8'h05, 8'h21, 12'h104, 2'd2, 32'h0);
    @(negedge clk);
    beat_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b1; req_bus = 8'h00; req_ofs = 12'h018;
    req_size = 2'd2; req_wdata = 32'h0000_0077;
    first = beat_data;
    chk("R10 port closed while busy", {63'h0, req_ready}, 64'h0);
    @(negedge clk);
    chk("R10 port still closed", {63'h0, req_ready}, 64'h0);
    chk("R9 beat unchanged under stall", beat_data, first);
    collect("R10 request during busy ignored", 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 no beat from dropped request", {63'h0, beat_valid}, 64'h0);
    end
    complete(1'b1);
  endtask

  task automatic t_root_update();
    send(1'b1, 8'h00, 8'h00, 12'h018, 2'd2, 32'h0007_0502);
    collect("R11 primary bus write", 1'b0);
    complete(1'b1);
    send(1'b0, 8'h02, 8'h00, 12'h000, 2'd2, 32'h0);
    collect("R11 read after root change", 1'b0);
    chk("R11 new root gives local type", {56'h0, rb[0][31:24]}, 64'h04);
    chk("R11 requester id follows root", {48'h0, rb[0][63:48]}, 64'h0200);
    complete(1'b1);
    send(1'b0, 8'h00, 8'h00, 12'h000, 2'd2, 32'h0);
    collect("R11 old root now routed", 1'b0);
    chk("R11 old root bus routed", {56'h0, rb[0][31:24]}, 64'h05);
    complete(1'b1);
  endtask

  task automatic t_root_no_update();
    send(1'b1, 8'h02, 8'h00, 12'h018, 2'd2, 32'h0000_0009);
    collect("R11 primary write, failed completion", 1'b0);
    complete(1'b0);
    send(1'b1, 8'h07, 8'h00, 12'h018, 2'd2, 32'h0000_000B);
    collect("R11 write to other bus", 1'b0);
    complete(1'b1);
    send(1'b0, 8'h02, 8'h00, 12'h000, 2'd2, 32'h0);
    collect("R11 root kept", 1'b0);
    chk("R11 root unchanged", {56'h0, rb[0][63:56]}, 64'h02);
    complete(1'b1);
  endtask

  initial begin
    checks = 0; failures = 0; finished = 1'b0;
    root_m = 8'h00; pend_m = 1'b0; pval_m = 8'h00;
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_bus = '0; req_devfn = '0;
    req_ofs = '0; req_size = '0; req_wdata = '0;
    cpl_valid = 1'b0; cpl_ok = 1'b0; beat_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_local();
    t_read_routed();
    t_write_aligned_byte();
    t_write_unaligned_half();
    t_stall_write();
    t_busy_drop();
    t_root_update();
    t_root_no_update();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule